// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Selectable Write Modes

This block is a word-organised synchronous memory with two ports, A and B, that share nothing but the stored words. Each port has its own enable, per-byte write strobes, address, write data and read data. All accesses are registered on the rising edge of a shared clock. A port does a write when it is enabled and at least one of its byte strobes is set. It does a read when it is enabled and no strobe is set.

Each port is given, at build time, one of three behaviours for its read data during a write: show the word as it was before the write, show the word as it is after the write, or leave the output untouched. A per-port parameter adds an output pipeline register, which trades one cycle of read latency for timing slack. A split parameter turns the array into two independent half-size memories. In that mode port A owns the lower half, port B owns the upper half, and the top address bit of each port is ignored. A combinational flag marks the cycles in which both ports would write the same physical word. The stored result of such a cycle is not defined.

Top module: `dual_port_ram`

## Requirements
- R1: While rst_ni is low, each port's read data equals the RST_VAL parameter, and it keeps that value after reset is released until the port's first enabled access.
- R2: An enabled access with all byte strobes clear returns the stored word at that address. The word appears after the access edge, or one edge later when the port has its output register.
- R3: A port in read-first mode (WMODE = 0) shows on a write the word stored at that address before the write.
- R4: A port in write-first mode (WMODE = 1) shows on a write the word as stored after the write.
- R5: A port in no-change mode (WMODE = 2) keeps its read data unchanged across a write.
- R6: Byte strobe bit i writes data bits [8i+7:8i] only. The other bytes of the addressed word keep their stored value.
- R7: While a port's enable is low, its strobes, address and data have no effect: nothing is written and the read data holds.
- R8: With the output register enabled, read data changes exactly one clock later than without it, and it holds the previous result during that extra cycle.
- R9: Both ports can operate in the same cycle on different words, and each gets its own correct result.
- R10: With SPLIT = 1, port A reaches only the lower half and port B only the upper half. The top address bit is ignored, so a write on one port never changes a word read by the other.
- R11: collide_o is high in exactly those cycles in which both ports are enabled, both have a byte strobe set, and both target the same physical word. With SPLIT = 1 it is never high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for both ports |
| rst_ni | input | 1 | Active-low asynchronous reset of the output registers |
| a_en_i | input | 1 | Port A access enable |
| a_we_i | input | DATA_W/8 | Port A byte write strobes |
| a_addr_i | input | ADDR_W | Port A word address |
| a_wdata_i | input | DATA_W | Port A write data |
| a_rdata_o | output | DATA_W | Port A read data |
| b_en_i | input | 1 | Port B access enable |
| b_we_i | input | DATA_W/8 | Port B byte write strobes |
| b_addr_i | input | ADDR_W | Port B word address |
| b_wdata_i | input | DATA_W | Port B write data |
| b_rdata_o | output | DATA_W | Port B read data |
| collide_o | output | 1 | Same-word write by both ports in this cycle |

## Verification
The assertions check the following on every cycle:
- an idle port holds its output;
- a no-change port holds its output through a write;
- a write-first port returns a fully strobed word;
- the pipeline stage lags the first stage by exactly one cycle;
- the collision flag only rises for matching addresses, and never in split mode.

Only the bench scenarios can show the rest: that the stored contents are right, that masked bytes keep their old values, that read-first returns old words, that split halves are isolated, and that concurrent accesses on different words do not interfere.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  typedef enum logic [1:0] {
    WM_READ_FIRST  = 2'd0,
    WM_WRITE_FIRST = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wmode_e;
endpackage

// File: rtl/dpram_array.sv
module dpram_array #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  localparam int LANES = DATA_W / 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic [LANES-1:0]  wr_a_i,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic [DATA_W-1:0] wdata_a_i,
  input  logic [LANES-1:0]  wr_b_i,
  input  logic [ADDR_W-1:0] addr_b_i,
  input  logic [DATA_W-1:0] wdata_b_i,
  output logic [DATA_W-1:0] word_a_o,
  output logic [DATA_W-1:0] word_b_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  assign word_a_o = mem_q[addr_a_i];
  assign word_b_o = mem_q[addr_b_i];

  // port B applied last; same-word result is undefined by contract
  always_ff @(posedge clk_i) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_a_i[l]) mem_q[addr_a_i][l*8 +: 8] <= wdata_a_i[l*8 +: 8];
    end
    for (int l = 0; l < LANES; l++) begin
      if (wr_b_i[l]) mem_q[addr_b_i][l*8 +: 8] <= wdata_b_i[l*8 +: 8];
    end
  end
endmodule

// File: rtl/dpram_port.sv
module dpram_port
  import dpram_pkg::*;
#(
  parameter int          DATA_W  = 16,
  parameter wmode_e      WMODE   = WM_READ_FIRST,
  parameter bit          OREG    = 1'b0,
  parameter logic [DATA_W-1:0] RST_VAL = '0,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [LANES-1:0]  wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] old_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] lat_q;
  logic              is_wr;

  assign is_wr = |wr_i;

  always_comb begin
    merged = old_i;
    for (int l = 0; l < LANES; l++) begin
      if (wr_i[l]) merged[l*8 +: 8] = wdata_i[l*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= RST_VAL;
    end else if (en_i) begin
      if (!is_wr) begin
        lat_q <= old_i;
      end else begin
        case (WMODE)
          WM_READ_FIRST:  lat_q <= old_i;
          WM_WRITE_FIRST: lat_q <= merged;
          default:        lat_q <= lat_q;
        endcase
      end
    end
  end

  generate
    if (OREG) begin : g_oreg
      logic [DATA_W-1:0] pipe_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= RST_VAL;
        else         pipe_q <= lat_q;
      end
      assign rdata_o = pipe_q;

      a_r8_one_stage_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdata_o == $past(lat_q));
    end else begin : g_direct
      assign rdata_o = lat_q;
    end

    if (WMODE == WM_NO_CHANGE) begin : g_nc_chk
      a_r5_hold_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && is_wr) |=> $stable(lat_q));
    end
    if (WMODE == WM_WRITE_FIRST) begin : g_wf_chk
      a_r4_full_word_shown: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && (&wr_i)) |=> (lat_q == $past(wdata_i)));
    end
  endgenerate

  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(lat_q));
endmodule

// File: rtl/dual_port_ram.sv
module dual_port_ram
  import dpram_pkg::*;
#(
  parameter int     DATA_W  = 16,
  parameter int     ADDR_W  = 4,
  parameter wmode_e WMODE_A = WM_READ_FIRST,
  parameter wmode_e WMODE_B = WM_WRITE_FIRST,
  parameter bit     OREG_A  = 1'b0,
  parameter bit     OREG_B  = 1'b1,
  parameter bit     SPLIT   = 1'b0,
  parameter logic [DATA_W-1:0] RST_VAL = '0,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_en_i,
  input  logic [LANES-1:0]  a_we_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  input  logic              b_en_i,
  input  logic [LANES-1:0]  b_we_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o,
  output logic              collide_o
);
  logic [ADDR_W-1:0] phys_a, phys_b;
  logic [LANES-1:0]  wr_a, wr_b;
  logic [DATA_W-1:0] word_a, word_b;

  always_comb begin
    phys_a = a_addr_i;
    phys_b = b_addr_i;
    if (SPLIT) begin
      phys_a[ADDR_W-1] = 1'b0;
      phys_b[ADDR_W-1] = 1'b1;
    end
  end

  assign wr_a = a_en_i ? a_we_i : '0;
  assign wr_b = b_en_i ? b_we_i : '0;
  assign collide_o = (|wr_a) && (|wr_b) && (phys_a == phys_b);

  dpram_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
    .clk_i     (clk_i),
    .wr_a_i    (wr_a),
    .addr_a_i  (phys_a),
    .wdata_a_i (a_wdata_i),
    .wr_b_i    (wr_b),
    .addr_b_i  (phys_b),
    .wdata_b_i (b_wdata_i),
    .word_a_o  (word_a),
    .word_b_o  (word_b)
  );

  dpram_port #(.DATA_W(DATA_W), .WMODE(WMODE_A), .OREG(OREG_A), .RST_VAL(RST_VAL)) u_port_a (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (a_en_i),
    .wr_i    (wr_a),
    .wdata_i (a_wdata_i),
    .old_i   (word_a),
    .rdata_o (a_rdata_o)
  );

  dpram_port #(.DATA_W(DATA_W), .WMODE(WMODE_B), .OREG(OREG_B), .RST_VAL(RST_VAL)) u_port_b (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (b_en_i),
    .wr_i    (wr_b),
    .wdata_i (b_wdata_i),
    .old_i   (word_b),
    .rdata_o (b_rdata_o)
  );

  generate
    if (SPLIT) begin : g_split_chk
      a_r10_no_cross_collide: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !collide_o);
    end else begin : g_full_chk
      a_r11_collide_same_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        collide_o |-> (a_addr_i == b_addr_i) && a_en_i && b_en_i);
    end
  endgenerate
endmodule

// File: tb/dual_port_ram_tb_top.sv
`timescale 1ns/100ps
module dual_port_ram_tb_top;
  import dpram_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  // dut_i: full array, A read-first direct, B write-first registered
  logic a_en, b_en;
  logic [1:0] a_we, b_we;
  logic [3:0] a_addr, b_addr;
  logic [15:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic coll;
  // dut2_i: split array, A no-change direct, B read-first direct
  logic c_en, d_en;
  logic [1:0] c_we, d_we;
  logic [3:0] c_addr, d_addr;
  logic [15:0] c_wdata, d_wdata, c_rdata, d_rdata;
  logic coll2;

  int checks = 0;
  int errors = 0;

  dual_port_ram #(.DATA_W(16), .ADDR_W(4), .WMODE_A(WM_READ_FIRST), .WMODE_B(WM_WRITE_FIRST),
    .OREG_A(1'b0), .OREG_B(1'b1), .SPLIT(1'b0), .RST_VAL(16'hDEAD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .a_en_i(a_en), .a_we_i(a_we), .a_addr_i(a_addr), .a_wdata_i(a_wdata), .a_rdata_o(a_rdata),
    .b_en_i(b_en), .b_we_i(b_we), .b_addr_i(b_addr), .b_wdata_i(b_wdata), .b_rdata_o(b_rdata),
    .collide_o(coll));

  dual_port_ram #(.DATA_W(16), .ADDR_W(4), .WMODE_A(WM_NO_CHANGE), .WMODE_B(WM_READ_FIRST),
    .OREG_A(1'b0), .OREG_B(1'b0), .SPLIT(1'b1), .RST_VAL(16'h5A5A)) dut2_i (
    .clk_i(clk), .rst_ni(rst_n),
    .a_en_i(c_en), .a_we_i(c_we), .a_addr_i(c_addr), .a_wdata_i(c_wdata), .a_rdata_o(c_rdata),
    .b_en_i(d_en), .b_we_i(d_we), .b_addr_i(d_addr), .b_wdata_i(d_wdata), .b_rdata_o(d_rdata),
    .collide_o(coll2));

  function automatic logic [15:0] pat_a(int k);
    return 16'(32'hA000 + k * 32'h0101);
  endfunction
  function automatic logic [15:0] pat_b(int k);
    return 16'(32'hB000 + k * 32'h0011);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_all();
    a_en = 0; a_we = 0; b_en = 0; b_we = 0;
    c_en = 0; c_we = 0; d_en = 0; d_we = 0;
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle_all();
    a_addr = 0; b_addr = 0; c_addr = 0; d_addr = 0;
    a_wdata = 0; b_wdata = 0; c_wdata = 0; d_wdata = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset A", a_rdata, 16'hDEAD);
    chk("R1 reset B", b_rdata, 16'hDEAD);
    chk("R1 reset C", c_rdata, 16'h5A5A);
    chk("R1 reset D", d_rdata, 16'h5A5A);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", a_rdata, 16'hDEAD);

    // R4 / R8: write-first on registered port B
    for (int k = 0; k < 16; k++) begin
      b_en = 1; b_we = 2'b11; b_addr = 4'(k); b_wdata = pat_b(k);
      @(negedge clk);
      idle_all();
      chk("R8 lag stage", b_rdata, (k == 0) ? 16'hDEAD : pat_b(k - 1));
      @(negedge clk);
      chk("R4 write-first", b_rdata, pat_b(k));
    end

    // R3: read-first on direct port A
    for (int k = 0; k < 16; k++) begin
      a_en = 1; a_we = 2'b11; a_addr = 4'(k); a_wdata = pat_a(k);
      @(negedge clk);
      idle_all();
      chk("R3 read-first", a_rdata, pat_b(k));
    end

    // R2: read sweep through B
    for (int k = 0; k < 16; k++) begin
      b_en = 1; b_we = 2'b00; b_addr = 4'(k);
      @(negedge clk);
      idle_all();
      @(negedge clk);
      chk("R2 read B", b_rdata, pat_a(k));
    end

    // R6: byte lanes
    a_en = 1; a_we = 2'b01; a_addr = 3; a_wdata = 16'h1234;
    @(negedge clk);
    a_we = 2'b10; a_addr = 5; a_wdata = 16'hCD77;
    @(negedge clk);
    a_we = 2'b00; a_addr = 3;
    @(negedge clk);
    chk("R6 low lane", a_rdata, {pat_a(3)[15:8], 8'h34});
    a_addr = 5;
    @(negedge clk);
    chk("R6 high lane", a_rdata, {8'hCD, pat_a(5)[7:0]});
    idle_all();

    // R7: disabled port ignores strobes
    a_en = 0; a_we = 2'b11; a_addr = 7; a_wdata = 16'hFFFF;
    @(negedge clk);
    @(negedge clk);
    chk("R7 output holds", a_rdata, {8'hCD, pat_a(5)[7:0]});
    a_en = 1; a_we = 2'b00; a_addr = 7;
    @(negedge clk);
    idle_all();
    chk("R7 no write", a_rdata, pat_a(7));

    // R9: concurrent write on A, read on B
    a_en = 1; a_we = 2'b11; a_addr = 9; a_wdata = 16'h0909;
    b_en = 1; b_we = 2'b00; b_addr = 10;
    @(negedge clk);
    idle_all();
    chk("R9 A result", a_rdata, pat_a(9));
    @(negedge clk);
    chk("R9 B result", b_rdata, pat_a(10));
    b_en = 1; b_addr = 9;
    @(negedge clk);
    idle_all();
    @(negedge clk);
    chk("R9 A write landed", b_rdata, 16'h0909);

    // R11: collision flag, combinational
    a_en = 1; a_we = 2'b01; a_addr = 12; a_wdata = 16'h1111;
    b_en = 1; b_we = 2'b10; b_addr = 12; b_wdata = 16'h2222;
    c_en = 1; c_we = 2'b11; c_addr = 12; c_wdata = 16'h3333;
    d_en = 1; d_we = 2'b11; d_addr = 12; d_wdata = 16'h4444;
    #1;
    chk("R11 same word", 16'(coll), 16'd1);
    chk("R11 split never", 16'(coll2), 16'd0);
    b_addr = 13;
    #0.5;
    chk("R11 other word", 16'(coll), 16'd0);
    b_addr = 12; b_we = 2'b00;
    #0.2;
    chk("R11 read not write", 16'(coll), 16'd0);
    idle_all();
    @(negedge clk);

    // R5 / R10 on split instance
    c_en = 1; c_we = 2'b11; c_addr = 4; c_wdata = 16'h1111;
    @(negedge clk);
    idle_all();
    chk("R5 no-change", c_rdata, 16'h5A5A);
    d_en = 1; d_we = 2'b11; d_addr = 4; d_wdata = 16'h2222;
    @(negedge clk);
    idle_all();
    c_en = 1; c_we = 2'b00; c_addr = 4;
    @(negedge clk);
    chk("R10 lower half isolated", c_rdata, 16'h1111);
    c_addr = 12;
    @(negedge clk);
    chk("R10 msb ignored", c_rdata, 16'h1111);
    c_en = 0;
    d_en = 1; d_we = 2'b00; d_addr = 4;
    @(negedge clk);
    chk("R10 upper half", d_rdata, 16'h2222);
    d_en = 0;
    c_en = 1; c_we = 2'b11; c_addr = 6; c_wdata = 16'h3333;
    @(negedge clk);
    idle_all();
    chk("R5 hold after read", c_rdata, 16'h1111);
    c_en = 1; c_we = 2'b00; c_addr = 6;
    @(negedge clk);
    idle_all();
    chk("R5 write stored", c_rdata, 16'h3333);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule